// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them and raises a single interrupt output towards the CPU. The CPU answers with two acknowledge strobes. The first strobe commits the winning line to service. The second strobe returns an 8-bit vector: a programmed base in the upper bits and the line number in the lower three bits.

Software drives the block through a byte-wide write port with a one-bit address. Address 0 takes command bytes and address 1 takes data bytes. A command byte with bit 4 set starts an initialization sequence. The next three data bytes supply, in order, the vector base, a cascade configuration byte, and a mode byte. Once that sequence is done, data bytes load the interrupt mask. Command bytes with bits 4 and 3 both clear are end-of-interrupt and priority commands.

A separate per-line input selects level or edge triggering for each line. Priority is fixed at first, with line 0 highest. Rotation commands can move the lowest-priority position.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A write to address 0 with bit 4 set starts initialization. The next three writes to address 1 are taken as the base byte, the cascade byte and the mode byte, in that order. The cascade byte appears on `cascadeCfg`, and `cascadeCfg` changes at no other time.
- R2: The vector is `{base[7:3], line[2:0]}`. Bits [2:0] of the base byte are ignored.
- R3: After initialization, a write to address 1 loads the mask, where bit i = 1 blocks line i. A blocked edge request stays latched and is raised once the line is unmasked.
- R4: Starting initialization clears the mask, the pending and in-service state, and any rotation, so line 0 is again highest. Bits 3, 1 and 0 of the initialization command have no effect. `intOut` is low in the cycle after the initialization command.
- R5: With default priority, the lowest-numbered of several pending unmasked lines is served first.
- R6: `intOut` is high only when an unmasked pending line has higher priority than every line currently in service. A pending line of equal or lower priority waits.
- R7: The first acknowledge strobe marks the winning line as in service and clears its edge request. The second strobe makes `vecValid` high for exactly one cycle, in the cycle after that strobe, with the vector on `vecOut`.
- R8: A command byte with bits [4:3] = 00 is decoded from bits [7:5]. 001 clears the highest-priority in-service line. 011 clears the in-service line named in bits [2:0].
- R9: Code 101 acts as 001, and code 111 acts as 011. Each also makes the cleared line the lowest priority.
- R10: Code 110 makes the line in bits [2:0] the lowest priority without clearing anything. Other codes (000, 010, 100) do nothing.
- R11: `lineTrigLevel[i]` = 0 selects edge triggering: a request is latched on a 0-to-1 transition, and holding the line high does not request again. `lineTrigLevel[i]` = 1 selects level triggering: the line requests while high, including after its end-of-interrupt.
- R12: If no line qualifies at the first strobe, for example because a level line fell before acknowledge, the vector carries line 7 and no in-service state changes.
- R13: Command bytes with bit 4 = 0 and bit 3 = 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| wrAddr | input | 1 | 0 = command byte, 1 = data byte |
| wrData | input | 8 | Write data |
| irqIn | input | 8 | Interrupt request lines |
| lineTrigLevel | input | 8 | Per line: 1 = level triggered, 0 = edge triggered |
| ackIn | input | 1 | Acknowledge strobe; successive cycles alternate first and second |
| intOut | output | 1 | Interrupt request to the CPU |
| vecOut | output | 8 | Vector returned on the second acknowledge |
| vecValid | output | 1 | One-cycle pulse marking `vecOut` valid |
| cascadeCfg | output | 8 | Stored cascade configuration byte |

## Verification
The hardest states to reach are those where several lines are in service at once while another request is pending, because only nested acknowledges without end-of-interrupt build them. The stimulus acknowledges one line, raises lower and higher lines, and acknowledges again without clearing. It then releases levels one at a time and watches `intOut` flip. The spurious case needs a level line to rise, raise `intOut`, and fall before the first strobe. The bench then confirms that line 7 was never put in service by raising it afterwards.

// File: rtl/virq_pkg.sv
package virq_pkg;
  parameter int NUM_LINES = 8;
  parameter int VEC_W = 8;
  localparam int LVL_W = $clog2(NUM_LINES);
  localparam int BASE_W = VEC_W - LVL_W;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadCascade;
    logic loadMask;
    logic eoiNonSpec;
    logic eoiSpec;
    logic rotateOnEoi;
    logic setLowest;
    logic ackFirst;
    logic ackSecond;
  } virqStrobe_t;
endpackage

// File: rtl/virq_prio_pick.sv
module virq_prio_pick #(
  parameter int N = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  reqVec,
  input  logic [LW-1:0] lowPri,
  output logic          anyHit,
  output logic [LW-1:0] hitLevel,
  output logic [LW-1:0] hitRank
);
  logic [LW-1:0] idx;

  // Walk from lowest to highest rank; the last hit is the highest priority.
  always_comb begin
    anyHit   = 1'b0;
    hitLevel = '0;
    hitRank  = '0;
    idx      = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = lowPri + LW'(k) + LW'(1);
      if (reqVec[idx]) begin
        anyHit   = 1'b1;
        hitLevel = idx;
        hitRank  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/virq_ctrl.sv
module virq_ctrl
  import virq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [7:3]  cmdBits,
  input  logic        ackIn,
  output virqStrobe_t strb
);
  typedef enum logic [1:0] {SEQ_RUN, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_e;

  seq_e seqState, seqNext;
  logic ackPhase;
  logic cmdWr, dataWr;

  assign cmdWr  = wrEn & ~wrAddr;
  assign dataWr = wrEn & wrAddr;

  always_comb begin
    strb    = '0;
    seqNext = seqState;
    if (cmdWr && cmdBits[4]) begin
      strb.initStart = 1'b1;
      seqNext        = SEQ_BASE;
    end else if (cmdWr && !cmdBits[3]) begin
      case (cmdBits[7:5])
        3'b001: strb.eoiNonSpec = 1'b1;
        3'b011: strb.eoiSpec = 1'b1;
        3'b101: begin
          strb.eoiNonSpec  = 1'b1;
          strb.rotateOnEoi = 1'b1;
        end
        3'b111: begin
          strb.eoiSpec     = 1'b1;
          strb.rotateOnEoi = 1'b1;
        end
        3'b110: strb.setLowest = 1'b1;
        default: ;
      endcase
    end else if (dataWr) begin
      case (seqState)
        SEQ_BASE: begin
          strb.loadBase = 1'b1;
          seqNext       = SEQ_CASC;
        end
        SEQ_CASC: begin
          strb.loadCascade = 1'b1;
          seqNext          = SEQ_MODE;
        end
        SEQ_MODE: seqNext = SEQ_RUN;
        default:  strb.loadMask = 1'b1;
      endcase
    end
    strb.ackFirst  = ackIn & ~ackPhase;
    strb.ackSecond = ackIn & ackPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_RUN;
      ackPhase <= 1'b0;
    end else begin
      seqState <= seqNext;
      if (cmdWr && cmdBits[4]) ackPhase <= 1'b0;
      else if (ackIn)          ackPhase <= ~ackPhase;
    end
  end
endmodule

// File: rtl/virq_datapath.sv
module virq_datapath
  import virq_pkg::*;
#(
  parameter int N  = NUM_LINES,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  virqStrobe_t   strb,
  input  logic [VW-1:0] wrData,
  input  logic [N-1:0]  irqIn,
  input  logic [N-1:0]  lineTrigLevel,
  output logic          intReq,
  output logic [VW-1:0] vecOut,
  output logic          vecValid,
  output logic [VW-1:0] cascadeCfg
);
  localparam int LW = $clog2(N);
  localparam int BW = VW - LW;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  irr, isr, mask, prevIrq;
  logic [N-1:0]  pending, riseVec, grantVec, eoiClr;
  logic [BW-1:0] base;
  logic [LW-1:0] lowPri, ackLevel;
  logic          pendHit, svcHit;
  logic [LW-1:0] pendLevel, pendRank, svcLevel, svcRank;

  assign pending = irr & ~mask;
  assign riseVec = irqIn & ~prevIrq;

  virq_prio_pick #(.N(N), .LW(LW)) pendPick_i (
    .reqVec(pending), .lowPri(lowPri),
    .anyHit(pendHit), .hitLevel(pendLevel), .hitRank(pendRank)
  );

  virq_prio_pick #(.N(N), .LW(LW)) svcPick_i (
    .reqVec(isr), .lowPri(lowPri),
    .anyHit(svcHit), .hitLevel(svcLevel), .hitRank(svcRank)
  );

  assign intReq   = pendHit && (!svcHit || (pendRank < svcRank));
  assign grantVec = (strb.ackFirst && intReq) ? (ONE << pendLevel) : '0;

  always_comb begin
    eoiClr = '0;
    if (strb.eoiSpec)                eoiClr = ONE << wrData[LW-1:0];
    else if (strb.eoiNonSpec && svcHit) eoiClr = ONE << svcLevel;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 irr[i] <= 1'b0;
      else if (strb.initStart)   irr[i] <= 1'b0;
      else if (lineTrigLevel[i]) irr[i] <= irqIn[i];
      else                       irr[i] <= (irr[i] | riseVec[i]) & ~grantVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isr     <= '0;
      mask    <= '0;
      prevIrq <= '1;
      lowPri  <= LW'(N - 1);
    end else if (strb.initStart) begin
      isr     <= '0;
      mask    <= '0;
      prevIrq <= '1;
      lowPri  <= LW'(N - 1);
    end else begin
      prevIrq <= irqIn;
      isr     <= (isr & ~eoiClr) | grantVec;
      if (strb.loadMask) mask <= wrData[N-1:0];
      if (strb.setLowest || (strb.rotateOnEoi && strb.eoiSpec))
        lowPri <= wrData[LW-1:0];
      else if (strb.rotateOnEoi && strb.eoiNonSpec && svcHit)
        lowPri <= svcLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base       <= '0;
      cascadeCfg <= '0;
      ackLevel   <= '0;
      vecOut     <= '0;
      vecValid   <= 1'b0;
    end else begin
      if (strb.loadBase)    base <= wrData[VW-1:LW];
      if (strb.loadCascade) cascadeCfg <= wrData;
      if (strb.ackFirst)    ackLevel <= intReq ? pendLevel : LW'(N - 1);
      if (strb.ackSecond)   vecOut <= {base, ackLevel};
      vecValid <= strb.ackSecond;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import virq_pkg::*;
#(
  parameter int N  = NUM_LINES,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wrAddr,
  input  logic [VW-1:0] wrData,
  input  logic [N-1:0]  irqIn,
  input  logic [N-1:0]  lineTrigLevel,
  input  logic          ackIn,
  output logic          intOut,
  output logic [VW-1:0] vecOut,
  output logic          vecValid,
  output logic [VW-1:0] cascadeCfg
);
  virqStrobe_t ctl;

  virq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .cmdBits(wrData[7:3]), .ackIn(ackIn), .strb(ctl)
  );

  virq_datapath #(.N(N), .VW(VW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(ctl), .wrData(wrData),
    .irqIn(irqIn), .lineTrigLevel(lineTrigLevel),
    .intReq(intOut), .vecOut(vecOut), .vecValid(vecValid),
    .cascadeCfg(cascadeCfg)
  );
endmodule

// File: rtl/virq_checker.sv
module virq_checker
  import virq_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          ackIn,
  input logic          intOut,
  input logic          vecValid,
  input logic [VW-1:0] cascadeCfg,
  input virqStrobe_t   ctl
);
  // R1
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.initStart, ctl.loadBase, ctl.loadCascade, ctl.loadMask,
              ctl.eoiNonSpec, ctl.eoiSpec, ctl.setLowest}));

  // R1
  cascade_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCascade |=> $stable(cascadeCfg));

  // R4
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.initStart |=> !intOut);

  // R7
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(ackIn));

  // R7
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);
endmodule

bind vec_irq_ctrl virq_checker #(.VW(VW)) chk_i (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .intOut(intOut),
  .vecValid(vecValid), .cascadeCfg(cascadeCfg), .ctl(ctl)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, wrAddr, ackIn;
  logic [7:0] wrData, irqIn, lineTrigLevel;
  logic       intOut, vecValid;
  logic [7:0] vecOut, cascadeCfg;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqIn(irqIn), .lineTrigLevel(lineTrigLevel), .ackIn(ackIn),
    .intOut(intOut), .vecOut(vecOut), .vecValid(vecValid), .cascadeCfg(cascadeCfg)
  );

  // {lines pulsed, expected vector}; base 0x20, edge lines, default priority
  localparam logic [15:0] STIM [12] = '{
    16'h0120, 16'h8027, 16'h2823, 16'h0025, 16'hFF20, 16'h0021,
    16'h0022, 16'h0023, 16'h0024, 16'h0025, 16'h0026, 16'h0027
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] l);
    @(negedge clk); irqIn = irqIn | l;
    @(negedge clk); irqIn = irqIn & ~l;
  endtask

  task automatic ackChk(input string req, input logic [7:0] exp);
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk);
    @(negedge clk); ackIn = 1'b0;
    chk(req, {7'b0, vecValid}, 8'h01);
    chk(req, vecOut, exp);
  endtask

  task automatic initSeq(input logic [7:0] c1, input logic [7:0] b, input logic [7:0] c3);
    wr(1'b0, c1); wr(1'b1, b); wr(1'b1, c3); wr(1'b1, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = 1'b0; wrData = '0; ackIn = 1'b0;
    irqIn = '0; lineTrigLevel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset intOut", {7'b0, intOut}, 8'h00);
    chk("reset vecValid", {7'b0, vecValid}, 8'h00);
    chk("reset cascadeCfg", cascadeCfg, 8'h00);

    // R1 sequence; R2 base low bits ignored
    initSeq(8'h11, 8'h23, 8'h04);
    chk("R1 cascade byte", cascadeCfg, 8'h04);

    // R2 R5 R7 table walk
    for (int n = 0; n < 12; n++) begin
      if (STIM[n][15:8] != 8'h00) pulse(STIM[n][15:8]);
      chk("R5 intOut pending", {7'b0, intOut}, 8'h01);
      ackChk("R2 R5 R7 vector", STIM[n][7:0]);
      wr(1'b0, 8'h20);
    end

    // R3 mask
    wr(1'b1, 8'h04);
    pulse(8'h04);
    chk("R3 masked line", {7'b0, intOut}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R3 unmasked latched", {7'b0, intOut}, 8'h01);
    ackChk("R3 vector", 8'h22);
    wr(1'b0, 8'h20);

    // R6 nesting, R13 ignored command
    pulse(8'h08);
    ackChk("R6 first", 8'h23);
    pulse(8'h20);
    chk("R6 lower waits", {7'b0, intOut}, 8'h00);
    wr(1'b0, 8'h28);
    chk("R13 bit3 command ignored", {7'b0, intOut}, 8'h00);
    pulse(8'h02);
    chk("R6 higher preempts", {7'b0, intOut}, 8'h01);
    ackChk("R6 nested", 8'h21);
    wr(1'b0, 8'h20);
    chk("R6 still blocked by 3", {7'b0, intOut}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R6 released", {7'b0, intOut}, 8'h01);
    ackChk("R6 last", 8'h25);
    wr(1'b0, 8'h20);

    // R8 specific EOI
    pulse(8'h10);
    ackChk("R8 setup", 8'h24);
    pulse(8'h02);
    ackChk("R8 setup2", 8'h21);
    wr(1'b0, 8'h64);
    wr(1'b0, 8'h20);
    pulse(8'h40);
    chk("R8 all cleared", {7'b0, intOut}, 8'h01);
    ackChk("R8 vector", 8'h26);
    wr(1'b0, 8'h20);

    // R9 rotate on non-specific EOI
    pulse(8'h01);
    ackChk("R9 setup", 8'h20);
    wr(1'b0, 8'hA0);
    pulse(8'h03);
    ackChk("R9 rotated", 8'h21);
    wr(1'b0, 8'h20);
    ackChk("R9 line0 last", 8'h20);
    wr(1'b0, 8'h20);

    // R10 set lowest, R9 rotate on specific EOI
    wr(1'b0, 8'hC4);
    pulse(8'h28);
    ackChk("R10 line5 first", 8'h25);
    wr(1'b0, 8'hE5);
    ackChk("R10 remaining", 8'h23);
    wr(1'b0, 8'h20);
    pulse(8'h41);
    ackChk("R9 after specific rotate", 8'h26);
    wr(1'b0, 8'h20);
    ackChk("R9 line0 after", 8'h20);
    wr(1'b0, 8'h20);

    // R4 reinit clears state
    wr(1'b1, 8'h01);
    pulse(8'h04);
    initSeq(8'h1B, 8'h48, 8'h02);
    chk("R4 pending cleared", {7'b0, intOut}, 8'h00);
    chk("R1 cascade reloaded", cascadeCfg, 8'h02);
    pulse(8'h81);
    ackChk("R4 priority and mask reset", 8'h48);
    wr(1'b0, 8'h20);
    ackChk("R4 line7", 8'h4F);
    wr(1'b0, 8'h20);

    // R11 edge hold
    @(negedge clk); irqIn[6] = 1'b1;
    @(negedge clk);
    ackChk("R11 edge", 8'h4E);
    wr(1'b0, 8'h20);
    @(negedge clk);
    chk("R11 held edge no repeat", {7'b0, intOut}, 8'h00);
    irqIn[6] = 1'b0;

    // R11 level
    lineTrigLevel[2] = 1'b1;
    @(negedge clk); irqIn[2] = 1'b1;
    @(negedge clk);
    chk("R11 level raises", {7'b0, intOut}, 8'h01);
    ackChk("R11 level vector", 8'h4A);
    wr(1'b0, 8'h20);
    chk("R11 level repeats", {7'b0, intOut}, 8'h01);
    ackChk("R11 level again", 8'h4A);
    irqIn[2] = 1'b0;
    @(negedge clk);
    wr(1'b0, 8'h20);
    chk("R11 level dropped", {7'b0, intOut}, 8'h00);

    // R12 spurious
    @(negedge clk); irqIn[2] = 1'b1;
    @(negedge clk);
    chk("R12 level up", {7'b0, intOut}, 8'h01);
    irqIn[2] = 1'b0;
    @(negedge clk);
    chk("R12 level gone", {7'b0, intOut}, 8'h00);
    ackChk("R12 spurious vector", 8'h4F);
    pulse(8'h80);
    chk("R12 line7 not in service", {7'b0, intOut}, 8'h01);
    ackChk("R12 real line7", 8'h4F);
    wr(1'b0, 8'h20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule